// File: doc/BRIEF.md
# First-Level Sharer Directory Controller

This block lives beside one bank of a shared second-level cache and keeps a copy of the tags held by the first-level caches of every core attached to it. Those caches write through, never allocate on a store, and treat each line as simply present or absent. Because the directory is a tag mirror organised by core, way and set, the bank can always tell exactly which first-level slots hold a given line without keeping per-line state bits of its own.

A request is either a load miss or a store. For a load miss the controller writes the requested tag into the mirror slot of the requesting core at the replacement way that core chose, strobes a bank read, and queues a fill message back to the core. For a store it strobes a bank write, compares the address against every core and way of the mirror in one cycle, queues one invalidation per matching slot belonging to a core other than the writer, clears those slots, and then pulses a visibility signal. Fills and invalidations share one outbound queue, so each core receives them in the order they were issued. When that queue is full no new request is accepted.

The controller is a single finite-state machine with seven states: IDLE (accept a request), LOOKUP (search the mirror and latch the sharer vector), LD_DIR (write the mirror and read the bank), LD_RET (queue the fill), ST_BANK (write the bank), ST_INV (queue one invalidation per cycle) and ST_VIS (announce visibility). Its transitions are: IDLE to LOOKUP on an accepted request; LOOKUP to LD_DIR for a load or to ST_BANK for a store; LD_DIR to LD_RET; LD_RET to IDLE once the fill is queued; ST_BANK to ST_INV; ST_INV to itself while sharers remain or the queue is full, and to ST_VIS when none remain; ST_VIS to IDLE. Core and way counts must be powers of two.

Top module: `dirc_ctrl`

## Requirements
- R1: After reset every mirror slot is invalid, `req_ready` is 1 and `msg_valid`, `gv_valid`, `bank_rd_en` and `bank_wr_en` are 0; a store issued right after reset produces no invalidation.
- R2: A load miss (`req_store`=0) from core C with way W, set S and tag T produces exactly one `bank_rd_en` pulse and exactly one fill message carrying core C, way W and set S, and leaves slot (C, W, S) valid with tag T.
- R3: A store to set S with tag T produces one invalidation message for each slot (core, way) at set S that is valid with tag T and belongs to a core other than the writer, carrying that core, way and set, and marks each such slot invalid; a slot at another set or with another tag receives nothing.
- R4: A store never invalidates a slot of the writing core; that slot stays valid and is invalidated by a later store to the same line from another core.
- R5: A store that misses in the writer's cache allocates no slot, so a later store from another core sends the earlier writer nothing.
- R6: Each store produces exactly one `gv_valid` pulse, carrying the writer in `gv_core`, in a cycle after its `bank_wr_en` pulse and after all of its invalidations have entered the queue; no request produces more than one of `bank_rd_en`, `bank_wr_en`, `gv_valid` in the same cycle.
- R7: Messages leave the block in the order they were issued, so a fill queued before a store's invalidation to the same core is delivered first.
- R8: While the outbound queue is full `req_ready` is 0 and a store waiting to queue invalidations stalls; a message presented with `msg_ready`=0 stays valid with unchanged fields, and no message is lost.
- R9: `msg_kind` is 0 for a fill and 1 for an invalidation.
- R10: The invalidations of one store are issued in ascending core number, and for one core in ascending way number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_store | input | 1 | 1 = store, 0 = load miss |
| req_core | input | log2(N_CORES) | Requesting core |
| req_way | input | log2(N_WAYS) | Replacement way chosen by the core (loads) |
| req_idx | input | IDX_W | First-level set |
| req_tag | input | TAG_W | Line tag |
| bank_rd_en | output | 1 | One-cycle bank read strobe |
| bank_wr_en | output | 1 | One-cycle bank write strobe |
| bank_idx | output | IDX_W | Set of the current request |
| bank_tag | output | TAG_W | Tag of the current request |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Outbound message taken |
| msg_kind | output | 1 | 0 fill, 1 invalidation |
| msg_core | output | log2(N_CORES) | Destination core |
| msg_way | output | log2(N_WAYS) | Destination way |
| msg_idx | output | IDX_W | Destination set |
| gv_valid | output | 1 | Store globally visible pulse |
| gv_core | output | log2(N_CORES) | Core whose store became visible |

## Verification
The bench fills every set with one line shared by all eight cores and stores from each set's chosen writer: a controller that forgot to mask the writer would send it a self-invalidation, and one that scanned in the wrong order would deliver the seven invalidations out of ascending core order. A second store from another core checks that the earlier writer's slot survived, while stores with a neighbouring tag or set expose a comparator that matches on index alone or tag alone. A store miss followed by a store from a third core catches a controller that allocated on stores. With the outbound side stalled, the bench fills the queue and checks that requests are refused and a pending store withholds visibility until every invalidation is queued; a controller that signalled visibility early or dropped a message under back-pressure would show a wrong count or order once the queue drains.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_LOOKUP  = 3'd1,
        S_LD_DIR  = 3'd2,
        S_LD_RET  = 3'd3,
        S_ST_BANK = 3'd4,
        S_ST_INV  = 3'd5,
        S_ST_VIS  = 3'd6
    } dirc_state_e;

    typedef enum logic {
        MSG_FILL = 1'b0,
        MSG_INV  = 1'b1
    } dirc_msg_e;

endpackage

// File: rtl/dirc_store.sv
// Tag mirror: one valid bit and tag per (core, way, set); parallel compare.
module dirc_store #(
    parameter int N_CORES = 8,
    parameter int N_WAYS  = 4,
    parameter int IDX_W   = 2,
    parameter int TAG_W   = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic                                     wr_valid,
    input  logic [$clog2(N_CORES)+$clog2(N_WAYS)-1:0] wr_ent,
    input  logic [IDX_W-1:0]                         wr_idx,
    input  logic [TAG_W-1:0]                         wr_tag,
    input  logic [IDX_W-1:0]                         look_idx,
    input  logic [TAG_W-1:0]                         look_tag,
    output logic [N_CORES*N_WAYS-1:0]                hit_vec
);
    localparam int N_ENT = N_CORES * N_WAYS;
    localparam int SETS  = 1 << IDX_W;

    logic [SETS-1:0]  vld_q [N_ENT];
    logic [TAG_W-1:0] tag_q [N_ENT][SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) begin
                vld_q[e] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_ent][wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) begin
            tag_q[wr_ent][wr_idx] <= wr_tag;
        end
    end

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit_vec[e] = vld_q[e][look_idx] && (tag_q[e][look_idx] == look_tag);
    end

endmodule

// File: rtl/dirc_pick.sv
// Lowest-index set bit finder (ascending core, then way).
module dirc_pick #(
    parameter int N = 32,
    parameter int W = 5
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] sel
);
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                sel = W'(i);
            end
        end
    end
endmodule

// File: rtl/dirc_fifo.sv
// Outbound message queue shared by fills and invalidations.
module dirc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem_q[rd_ptr_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data;
    end
endmodule

// File: rtl/dirc_ctrl.sv
module dirc_ctrl
    import dirc_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int N_WAYS  = 4,
    parameter int IDX_W   = 2,
    parameter int TAG_W   = 8,
    parameter int Q_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_store,
    input  logic [$clog2(N_CORES)-1:0] req_core,
    input  logic [$clog2(N_WAYS)-1:0]  req_way,
    input  logic [IDX_W-1:0]           req_idx,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       bank_rd_en,
    output logic                       bank_wr_en,
    output logic [IDX_W-1:0]           bank_idx,
    output logic [TAG_W-1:0]           bank_tag,
    output logic                       msg_valid,
    input  logic                       msg_ready,
    output logic                       msg_kind,
    output logic [$clog2(N_CORES)-1:0] msg_core,
    output logic [$clog2(N_WAYS)-1:0]  msg_way,
    output logic [IDX_W-1:0]           msg_idx,
    output logic                       gv_valid,
    output logic [$clog2(N_CORES)-1:0] gv_core
);
    localparam int CORE_W = $clog2(N_CORES);
    localparam int WAY_W  = $clog2(N_WAYS);
    localparam int N_ENT  = N_CORES * N_WAYS;
    localparam int ENT_W  = CORE_W + WAY_W;
    localparam int MSG_W  = 1 + CORE_W + WAY_W + IDX_W;

    dirc_state_e state_q, state_d;

    logic              r_store;
    logic [CORE_W-1:0] r_core;
    logic [WAY_W-1:0]  r_way;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [N_ENT-1:0]  pend_q;
    logic              accept;

    logic [N_ENT-1:0]  hit_vec, writer_mask;
    logic              pick_any;
    logic [ENT_W-1:0]  pick_sel;

    logic              dir_we, dir_wvalid;
    logic [ENT_W-1:0]  dir_went;
    logic              pend_clr;

    logic              q_full, q_push;
    dirc_msg_e         push_kind;
    logic [CORE_W-1:0] push_core;
    logic [WAY_W-1:0]  push_way;
    logic [MSG_W-1:0]  q_in, q_out;

    dirc_store #(
        .N_CORES(N_CORES), .N_WAYS(N_WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dir_we), .wr_valid(dir_wvalid), .wr_ent(dir_went),
        .wr_idx(r_idx), .wr_tag(r_tag),
        .look_idx(r_idx), .look_tag(r_tag),
        .hit_vec(hit_vec)
    );

    dirc_pick #(.N(N_ENT), .W(ENT_W)) pick_i (
        .vec(pend_q), .any(pick_any), .sel(pick_sel)
    );

    assign q_in = {push_kind, push_core, push_way, r_idx};

    dirc_fifo #(.W(MSG_W), .DEPTH(Q_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data(q_in), .full(q_full),
        .out_valid(msg_valid), .out_ready(msg_ready), .out_data(q_out)
    );

    assign msg_kind = q_out[MSG_W-1];
    assign msg_core = q_out[MSG_W-2 -: CORE_W];
    assign msg_way  = q_out[IDX_W+WAY_W-1 -: WAY_W];
    assign msg_idx  = q_out[IDX_W-1:0];

    for (genvar e = 0; e < N_ENT; e++) begin : g_wmask
        assign writer_mask[e] = ((e / N_WAYS) == int'(r_core));
    end

    assign bank_idx = r_idx;
    assign bank_tag = r_tag;
    assign gv_core  = r_core;
    assign accept   = req_valid && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and pending-sharer vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_store <= 1'b0;
            r_core  <= '0;
            r_way   <= '0;
            r_idx   <= '0;
            r_tag   <= '0;
            pend_q  <= '0;
        end else begin
            if (accept) begin
                r_store <= req_store;
                r_core  <= req_core;
                r_way   <= req_way;
                r_idx   <= req_idx;
                r_tag   <= req_tag;
            end
            if (state_q == S_LOOKUP) pend_q <= hit_vec & ~writer_mask;
            else if (pend_clr)       pend_q[pick_sel] <= 1'b0;
        end
    end

    // Outputs and next state
    always_comb begin
        state_d    = state_q;
        req_ready  = 1'b0;
        bank_rd_en = 1'b0;
        bank_wr_en = 1'b0;
        gv_valid   = 1'b0;
        dir_we     = 1'b0;
        dir_wvalid = 1'b0;
        dir_went   = {r_core, r_way};
        pend_clr   = 1'b0;
        q_push     = 1'b0;
        push_kind  = MSG_FILL;
        push_core  = r_core;
        push_way   = r_way;
        unique case (state_q)
            S_IDLE: begin
                req_ready = !q_full;
                if (req_valid && !q_full) state_d = S_LOOKUP;
            end
            S_LOOKUP: begin
                state_d = r_store ? S_ST_BANK : S_LD_DIR;
            end
            S_LD_DIR: begin
                dir_we     = 1'b1;
                dir_wvalid = 1'b1;
                bank_rd_en = 1'b1;
                state_d    = S_LD_RET;
            end
            S_LD_RET: begin
                if (!q_full) begin
                    q_push  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_ST_BANK: begin
                bank_wr_en = 1'b1;
                state_d    = S_ST_INV;
            end
            S_ST_INV: begin
                if (!pick_any) begin
                    state_d = S_ST_VIS;
                end else if (!q_full) begin
                    q_push    = 1'b1;
                    push_kind = MSG_INV;
                    push_core = pick_sel[ENT_W-1 -: CORE_W];
                    push_way  = pick_sel[WAY_W-1:0];
                    dir_we    = 1'b1;
                    dir_went  = pick_sel;
                    pend_clr  = 1'b1;
                end
            end
            S_ST_VIS: begin
                gv_valid = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

endmodule

// File: rtl/dirc_checker.sv
module dirc_checker #(
    parameter int CORE_W = 3,
    parameter int WAY_W  = 2,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bank_rd_en,
    input logic              bank_wr_en,
    input logic              gv_valid,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              msg_kind,
    input logic [CORE_W-1:0] msg_core,
    input logic [WAY_W-1:0]  msg_way,
    input logic [IDX_W-1:0]  msg_idx,
    input logic              q_full,
    input logic              q_push,
    input logic              push_kind,
    input logic [CORE_W-1:0] push_core,
    input logic [CORE_W-1:0] r_core
);
    logic wr_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wr_seen_q <= 1'b0;
        else if (bank_wr_en) wr_seen_q <= 1'b1;
        else if (gv_valid)   wr_seen_q <= 1'b0;
    end

    a_r8_full_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !req_ready);

    a_r8_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable({msg_kind, msg_core, msg_way, msg_idx})));

    a_r6_vis_after_bank: assert property (@(posedge clk) disable iff (!rst_n)
        gv_valid |-> wr_seen_q);

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_rd_en, bank_wr_en, gv_valid}));

    a_r2_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r4_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && push_kind) |-> (push_core != r_core));

endmodule

bind dirc_ctrl dirc_checker #(
    .CORE_W(CORE_W), .WAY_W(WAY_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en), .gv_valid(gv_valid),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_core(msg_core), .msg_way(msg_way), .msg_idx(msg_idx),
    .q_full(q_full), .q_push(q_push), .push_kind(push_kind),
    .push_core(push_core), .r_core(r_core)
);

// File: tb/dirc_ctrl_tb_top.sv
`timescale 1ns/1ps
module dirc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_store = 1'b0;
    logic [2:0] req_core = '0;
    logic [1:0] req_way = '0;
    logic [1:0] req_idx = '0;
    logic [7:0] req_tag = '0;
    logic       req_ready, bank_rd_en, bank_wr_en;
    logic [1:0] bank_idx;
    logic [7:0] bank_tag;
    logic       msg_valid, msg_kind;
    logic       msg_ready = 1'b1;
    logic [2:0] msg_core, gv_core;
    logic [1:0] msg_way, msg_idx;
    logic       gv_valid;

    always #10 clk = ~clk;

    dirc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_core(req_core), .req_way(req_way), .req_idx(req_idx), .req_tag(req_tag),
        .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en),
        .bank_idx(bank_idx), .bank_tag(bank_tag),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_core(msg_core), .msg_way(msg_way), .msg_idx(msg_idx),
        .gv_valid(gv_valid), .gv_core(gv_core)
    );

    int checks = 0, errors = 0;
    int cyc = 0, wr_cyc = 0, gv_cyc = 0, gv_cnt = 0, gv_last = 0, rd_cnt = 0;
    int log_n = 0, exp_n = 0, cmp_ptr = 0;
    int log_k [512], log_c [512], log_w [512], log_i [512];
    int exp_k [512], exp_c [512], exp_w [512], exp_i [512];
    bit     bv [8][4][4];
    int     bt [8][4][4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (msg_valid && msg_ready && log_n < 512) begin
            log_k[log_n] = int'(msg_kind);
            log_c[log_n] = int'(msg_core);
            log_w[log_n] = int'(msg_way);
            log_i[log_n] = int'(msg_idx);
            log_n++;
        end
        if (bank_wr_en) wr_cyc = cyc;
        if (bank_rd_en) rd_cnt++;
        if (gv_valid) begin
            gv_cyc = cyc;
            gv_cnt++;
            gv_last = int'(gv_core);
        end
    end

    task automatic push_exp(input int k, input int c, input int w, input int i);
        exp_k[exp_n] = k; exp_c[exp_n] = c; exp_w[exp_n] = w; exp_i[exp_n] = i;
        exp_n++;
    endtask

    // Reference: fill kind 0 on load; inv kind 1 to other matching slots, ascending.
    task automatic model(input bit st, input int c, input int w, input int i, input int t);
        if (!st) begin
            bv[c][w][i] = 1'b1;
            bt[c][w][i] = t;
            push_exp(0, c, w, i);
        end else begin
            for (int cc = 0; cc < 8; cc++) begin
                for (int ww = 0; ww < 4; ww++) begin
                    if (cc != c && bv[cc][ww][i] && bt[cc][ww][i] == t) begin
                        push_exp(1, cc, ww, i);
                        bv[cc][ww][i] = 1'b0;
                    end
                end
            end
        end
    endtask

    task automatic send(input bit st, input int c, input int w, input int i, input int t);
        req_store = st;
        req_core  = 3'(c);
        req_way   = 2'(w);
        req_idx   = 2'(i);
        req_tag   = 8'(t);
        req_valid = 1'b1;
        for (int n = 0; n < 300 && !req_ready; n++) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        for (int n = 0; n < 100 && !(req_ready && !msg_valid); n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare(input string req);
        for (int k = cmp_ptr; k < exp_n; k++) begin
            chk(k < log_n && log_k[k] == exp_k[k] && log_c[k] == exp_c[k] &&
                log_w[k] == exp_w[k] && log_i[k] == exp_i[k], req,
                log_k[k]*1000 + log_c[k]*100 + log_w[k]*10 + log_i[k],
                exp_k[k]*1000 + exp_c[k]*100 + exp_w[k]*10 + exp_i[k]);
        end
        chk(log_n == exp_n, {req, " message count"}, log_n, exp_n);
        cmp_ptr = exp_n;
    endtask

    task automatic op(input bit st, input int c, input int w, input int i, input int t,
                      input string req);
        int gv0, rd0;
        gv0 = gv_cnt;
        rd0 = rd_cnt;
        model(st, c, w, i, t);
        send(st, c, w, i, t);
        wait_idle();
        if (st) begin
            chk(gv_cnt == gv0 + 1, "R6 one visibility pulse", gv_cnt - gv0, 1);
            chk(gv_cyc > wr_cyc, "R6 visibility after bank write", gv_cyc, wr_cyc + 1);
            chk(gv_last == c, "R6 visibility core", gv_last, c);
        end else begin
            chk(rd_cnt == rd0 + 1, "R2 one bank read", rd_cnt - rd0, 1);
        end
        compare(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base, mv0, mv1, mv2;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !msg_valid && !gv_valid && !bank_rd_en && !bank_wr_en,
            "R1 idle outputs", int'({req_ready, msg_valid, gv_valid, bank_rd_en, bank_wr_en}), 16);

        // R1: empty mirror
        op(1'b1, 0, 0, 0, 0, "R1 store after reset");

        // R2 / R9: every core loads each set's line
        for (int i = 0; i < 4; i++)
            for (int c = 0; c < 8; c++)
                op(1'b0, c, (c + i) % 4, i, 'h10 + i, "R2/R9 fill");

        // R3 / R10 / R4: store per set, then from another core
        for (int i = 0; i < 4; i++) begin
            base = log_n;
            op(1'b1, 2*i, 0, i, 'h10 + i, "R3/R9 invalidations");
            chk(log_n - base == 7, "R3 seven sharers", log_n - base, 7);
            for (int k = base + 1; k < log_n; k++)
                chk(log_c[k] > log_c[k-1], "R10 ascending core", log_c[k], log_c[k-1] + 1);
            base = log_n;
            op(1'b1, 2*i + 1, 0, i, 'h10 + i, "R4 writer kept");
            chk(log_n - base == 1 && log_c[base] == 2*i, "R4 only old writer",
                log_c[base], 2*i);
        end

        // R3: neighbouring tag and set do not match
        op(1'b0, 4, 1, 3, 'h77, "R2 fill");
        base = log_n;
        op(1'b1, 5, 0, 3, 'h78, "R3 other tag");
        op(1'b1, 5, 0, 2, 'h77, "R3 other set");
        chk(log_n == base, "R3 no mismatch inv", log_n - base, 0);
        op(1'b1, 5, 0, 3, 'h77, "R3 exact match");
        chk(log_n == base + 1 && log_c[base] == 4 && log_w[base] == 1, "R3 match target",
            log_c[base]*10 + log_w[base], 41);

        // R5: no allocation on store
        op(1'b1, 3, 0, 1, 'h55, "R5 store miss");
        op(1'b0, 6, 2, 1, 'h55, "R2 fill");
        base = log_n;
        op(1'b1, 7, 0, 1, 'h55, "R5 later store");
        chk(log_n == base + 1 && log_c[base] == 6, "R5 writer not allocated",
            log_c[base], 6);

        // R7 / R8: ordering and hold while stalled
        msg_ready = 1'b0;
        model(1'b0, 1, 2, 2, 'h99);
        send(1'b0, 1, 2, 2, 'h99);
        repeat (4) @(negedge clk);
        model(1'b1, 0, 0, 2, 'h99);
        send(1'b1, 0, 0, 2, 'h99);
        repeat (10) @(negedge clk);
        chk(msg_valid == 1'b1, "R8 message pending", int'(msg_valid), 1);
        mv0 = int'(msg_kind); mv1 = int'(msg_core); mv2 = int'(msg_way);
        repeat (3) @(negedge clk);
        chk(msg_valid && int'(msg_kind) == mv0 && int'(msg_core) == mv1 &&
            int'(msg_way) == mv2, "R8 message held", int'(msg_core), mv1);
        base = log_n;
        msg_ready = 1'b1;
        wait_idle();
        chk(log_k[base] == 0 && log_k[base+1] == 1 && log_c[base+1] == 1,
            "R7 fill before invalidate", log_k[base]*10 + log_k[base+1], 1);
        compare("R7 order");

        // R8: full queue refuses requests
        msg_ready = 1'b0;
        for (int c = 0; c < 4; c++) begin
            model(1'b0, c, 3, 0, 'hA0 + c);
            send(1'b0, c, 3, 0, 'hA0 + c);
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk(req_ready == 1'b0, "R8 ready low when full", int'(req_ready), 0);
        msg_ready = 1'b1;
        wait_idle();
        chk(req_ready == 1'b1, "R8 ready after drain", int'(req_ready), 1);
        compare("R8 no loss");

        // R6 / R8: store stalls on full queue and withholds visibility
        for (int c = 1; c < 8; c++) op(1'b0, c, c % 4, 3, 'hC3, "R2 fill");
        msg_ready = 1'b0;
        base = gv_cnt;
        model(1'b1, 0, 0, 3, 'hC3);
        send(1'b1, 0, 0, 3, 'hC3);
        repeat (20) @(negedge clk);
        chk(gv_cnt == base, "R6 no visibility before all inv queued", gv_cnt - base, 0);
        msg_ready = 1'b1;
        wait_idle();
        chk(gv_cnt == base + 1, "R6 visibility after drain", gv_cnt - base, 1);
        compare("R8 stalled store");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule